// File: doc/BRIEF.md
# Double-Column Token Readout and Serialiser

This block sits at the bottom of one double column of four-pixel regions and handles the readout side of a hit's life. First a hit is stored in a region. Then a trigger arrives. Then the periphery reads the region and shifts its data out. A trigger request latches the trigger ID to be served. From then on, every region that holds an event stored under that ID raises a token. The combined token is reported on `token_out` so that the outside controller knows data is pending.

When the external read line is high and the serialiser is idle, the lowest-numbered region holding a token is served. Its four pixels of time-over-threshold and neighbour data are packed together with the region's address and the trigger ID into one raw 32-bit word. No coding or formatting is applied. The word is then shifted out MSB-first, one bit per cycle of a generated serial clock. The served region drops out of the token chain until the next trigger request. Two configuration bits control the token. One enables this column's own regions. The other merges a token arriving from a neighbouring column into the output.

Top module: `dcro_top`

## Requirements
- R1: A served word is 32 bits. For pixel p = 0..3, bits [31-5p : 27-5p] hold {ToT[3:0], NL}, taken from `reg_data` bits [20r+5p+4 : 20r+5p+1] (ToT) and [20r+5p] (NL) of region r. Bits [11:4] hold the region index r. Bits [3:0] hold the latched trigger ID.
- R2: The word leaves on `ser_data` MSB-first. Each bit is held for two `clk` cycles: `ser_clk` is low in the first and high in the second, so a receiver samples on the rising edge of `ser_clk`. A word takes 32 `ser_clk` periods.
- R3: `busy` rises on the load edge and stays high for exactly 64 cycles. While `busy` is low, `ser_data` and `ser_clk` are low.
- R4: When several regions hold a token, the lowest region index is served first.
- R5: A region's token drops once its word has been loaded. `token_out` falls when no region is left pending and `tok_in` is not merged.
- R6: A region is pending only when it is valid and its stored trigger ID equals the latched request ID. A read with no pending region loads nothing.
- R7: A pulse on `trig_req` latches `trig_id` and re-arms every region that was already served.
- R8: In region 30, the topmost region, pixels 2 and 3 are emitted as zero whatever their inputs are.
- R9: With `cfg_dc_en` low, no local region raises a token and a read loads nothing.
- R10: With `cfg_chain_en` high, `tok_in` is ORed into `token_out`. With it low, `tok_in` has no effect.
- R11: After reset, `busy`, `ser_clk`, `ser_data` and the local token are low.
- R12: A read while `busy` is high does not disturb the word in flight. A read in the same cycle as `trig_req` loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dc_en | input | 1 | Enables this column's regions in the token chain |
| cfg_chain_en | input | 1 | Merges `tok_in` into `token_out` |
| trig_req | input | 1 | Latches `trig_id` and re-arms served regions |
| trig_id | input | 4 | Trigger ID to serve |
| rd | input | 1 | External read request |
| reg_valid | input | 31 | Per-region event present |
| reg_id | input | 124 | Per-region stored trigger ID, 4 bits each |
| reg_data | input | 620 | Per-region pixel data, 20 bits each |
| tok_in | input | 1 | Token from a neighbouring column |
| token_out | output | 1 | Data pending |
| busy | output | 1 | Serialiser active |
| ser_clk | output | 1 | Serial output clock |
| ser_data | output | 1 | Serial output data |

## Verification
The hardest case to reach from the ports is a read that arrives while a word is still in flight, with another region still pending. The bench holds `rd` high through an entire word. It checks that the first word comes out intact and that the next load waits until `busy` has fallen. Priority and token drop are covered by loading two matching regions in reverse index order. The bench then reads them out and confirms that `token_out` stays high after the first word and falls after the second.

// File: rtl/dcro_pkg.sv
// Shared types for the double-column readout.
// Assumes nothing beyond a single clock domain.
package dcro_pkg;
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } ser_phase_t;
endpackage

// File: rtl/dcro_token_scan.sv
// Computes per-region pending flags and picks the lowest pending index.
// Assumes the served mask and the request ID are registered upstream.
module dcro_token_scan #(
    parameter int NREG  = 31,
    parameter int ID_W  = 4,
    parameter int IDX_W = 5
) (
    input  logic                 en,
    input  logic [NREG-1:0]      valid,
    input  logic [NREG-1:0]      served,
    input  logic [NREG*ID_W-1:0] ids,
    input  logic [ID_W-1:0]      req_id,
    output logic [NREG-1:0]      pend,
    output logic                 any_pend,
    output logic [IDX_W-1:0]     first
);
    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_pend
            // a region is pending when enabled, present, unserved and ID-matched
            assign pend[r] = en & valid[r] & ~served[r] &
                             (ids[r*ID_W +: ID_W] == req_id);
        end
    endgenerate

    // any pending region raises the column token
    assign any_pend = |pend;

    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        first = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend[i]) first = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dcro_word_pack.sv
// Assembles the raw output word of the selected region.
// Assumes sel always names an existing region; the topmost region has
// its highest TOP_TIED pixels forced to zero.
module dcro_word_pack #(
    parameter int NREG     = 31,
    parameter int NPIX     = 4,
    parameter int TOT_W    = 4,
    parameter int ADDR_W   = 8,
    parameter int ID_W     = 4,
    parameter int IDX_W    = 5,
    parameter int TOP_TIED = 2,
    localparam int PB      = TOT_W + 1,
    localparam int RB      = NPIX * PB,
    localparam int WORD_W  = RB + ADDR_W + ID_W
) (
    input  logic [NREG*RB-1:0] data,
    input  logic [IDX_W-1:0]   sel,
    input  logic [ID_W-1:0]    req_id,
    output logic [WORD_W-1:0]  word
);
    logic [RB-1:0] raw;
    logic          is_top;

    // pick the payload of the served region
    always_comb raw = data[int'(sel)*RB +: RB];

    // flag the topmost region whose upper pixels are tied low
    assign is_top = (sel == IDX_W'(NREG - 1));

    genvar p;
    generate
        for (p = 0; p < NPIX; p++) begin : g_pix
            if (p >= NPIX - TOP_TIED) begin : g_tied
                // tied-low pixels of the top region read as zero
                assign word[WORD_W-1-p*PB -: PB] = is_top ? '0 : raw[p*PB +: PB];
            end else begin : g_free
                // ordinary pixel: {ToT, neighbour} copied through
                assign word[WORD_W-1-p*PB -: PB] = raw[p*PB +: PB];
            end
        end
    endgenerate

    // address and trigger ID close the word
    assign word[ADDR_W+ID_W-1:ID_W] = ADDR_W'(sel);
    assign word[ID_W-1:0]           = req_id;
endmodule

// File: rtl/dcro_piso.sv
// Parallel-in serial-out shifter with a generated serial clock.
// Each bit is held for a low and a high phase; MSB leaves first.
// Assumes load is only raised while busy is low.
module dcro_piso
    import dcro_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              busy,
    output logic              ser_clk,
    output logic              ser_data
);
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  bitcnt;
    ser_phase_t        phase;

    // load, phase toggling and MSB-first shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            bitcnt <= '0;
            phase  <= PH_LO;
            busy   <= 1'b0;
        end else if (load) begin
            sreg   <= word_in;
            bitcnt <= '0;
            phase  <= PH_LO;
            busy   <= 1'b1;
        end else if (busy) begin
            if (phase == PH_LO) begin
                phase <= PH_HI;
            end else begin
                phase <= PH_LO;
                if (bitcnt == CNT_W'(WORD_W - 1)) begin
                    busy <= 1'b0;
                    sreg <= '0;
                end else begin
                    sreg   <= {sreg[WORD_W-2:0], 1'b0};
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // outputs stay quiet while idle
    assign ser_data = busy & sreg[WORD_W-1];
    assign ser_clk  = busy & (phase == PH_HI);
endmodule

// File: rtl/dcro_top.sv
// Periphery readout of one double column: token chain, region
// selection, word assembly and serial output.
// Assumes region inputs stay stable while their word is being read.
module dcro_top #(
    parameter int NREG     = 31,
    parameter int NPIX     = 4,
    parameter int TOT_W    = 4,
    parameter int ADDR_W   = 8,
    parameter int ID_W     = 4,
    parameter int TOP_TIED = 2,
    localparam int IDX_W   = $clog2(NREG),
    localparam int RB      = NPIX * (TOT_W + 1),
    localparam int WORD_W  = RB + ADDR_W + ID_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_dc_en,
    input  logic                 cfg_chain_en,
    input  logic                 trig_req,
    input  logic [ID_W-1:0]      trig_id,
    input  logic                 rd,
    input  logic [NREG-1:0]      reg_valid,
    input  logic [NREG*ID_W-1:0] reg_id,
    input  logic [NREG*RB-1:0]   reg_data,
    input  logic                 tok_in,
    output logic                 token_out,
    output logic                 busy,
    output logic                 ser_clk,
    output logic                 ser_data
);
    logic [ID_W-1:0]   req_id;
    logic [NREG-1:0]   served;
    logic [NREG-1:0]   pend;
    logic              any_pend;
    logic [IDX_W-1:0]  first;
    logic [WORD_W-1:0] word;
    logic              load;

    dcro_token_scan #(.NREG(NREG), .ID_W(ID_W), .IDX_W(IDX_W)) u_scan (
        .en(cfg_dc_en), .valid(reg_valid), .served(served), .ids(reg_id),
        .req_id(req_id), .pend(pend), .any_pend(any_pend), .first(first)
    );

    dcro_word_pack #(
        .NREG(NREG), .NPIX(NPIX), .TOT_W(TOT_W), .ADDR_W(ADDR_W),
        .ID_W(ID_W), .IDX_W(IDX_W), .TOP_TIED(TOP_TIED)
    ) u_pack (
        .data(reg_data), .sel(first), .req_id(req_id), .word(word)
    );

    // a read starts a word only when idle, pending and not re-arming
    assign load = rd & ~busy & any_pend & ~trig_req;

    // latch the requested ID and track which regions were served
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_id <= '0;
            served <= '0;
        end else if (trig_req) begin
            req_id <= trig_id;
            served <= '0;
        end else if (load) begin
            served[first] <= 1'b1;
        end
    end

    // column token merged with the neighbour token when chained
    assign token_out = any_pend | (cfg_chain_en & tok_in);

    dcro_piso #(.WORD_W(WORD_W)) u_piso (
        .clk(clk), .rst_n(rst_n), .load(load), .word_in(word),
        .busy(busy), .ser_clk(ser_clk), .ser_data(ser_data)
    );
endmodule

// File: rtl/dcro_checks.sv
// Protocol checks on the readout ports, bound to dcro_top.
module dcro_checks #(
    parameter int WORD_W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic ser_clk,
    input logic ser_data,
    input logic cfg_dc_en,
    input logic cfg_chain_en,
    input logic trig_req,
    input logic token_out
);
    localparam int SPAN = 2 * WORD_W;
    logic [$clog2(SPAN+1)-1:0] bcnt;

    // counts cycles spent busy
    always_ff @(posedge clk) begin
        if (!rst_n) bcnt <= '0;
        else        bcnt <= busy ? bcnt + 1'b1 : '0;
    end

    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (bcnt != ($bits(bcnt))'(SPAN - 1)) |=> busy);
    a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (bcnt == ($bits(bcnt))'(SPAN - 1)) |=> !busy);
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_data && !ser_clk);
    a_r2_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> ser_clk != $past(ser_clk));
    a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ser_clk |-> $stable(ser_data));
    a_r9_no_load_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !cfg_dc_en |=> !busy);
    a_r12_trig_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && trig_req |=> !busy);
    a_r10_token_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dc_en && !cfg_chain_en |-> !token_out);
endmodule

bind dcro_top dcro_checks #(.WORD_W(WORD_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ser_clk(ser_clk),
    .ser_data(ser_data), .cfg_dc_en(cfg_dc_en), .cfg_chain_en(cfg_chain_en),
    .trig_req(trig_req), .token_out(token_out)
);

// File: tb/dcro_top_tb_top.sv
module dcro_top_tb_top;
    localparam int NREG = 31;
    localparam int ID_W = 4;
    localparam int RB   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dc_en = 1'b1, cfg_chain_en = 1'b0;
    logic trig_req = 1'b0, rd = 1'b0, tok_in = 1'b0;
    logic [ID_W-1:0] trig_id = '0;
    logic [NREG-1:0] reg_valid = '0;
    logic [NREG*ID_W-1:0] reg_id = '0;
    logic [NREG*RB-1:0] reg_data = '0;
    logic token_out, busy, ser_clk, ser_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dcro_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dc_en(cfg_dc_en),
        .cfg_chain_en(cfg_chain_en), .trig_req(trig_req), .trig_id(trig_id),
        .rd(rd), .reg_valid(reg_valid), .reg_id(reg_id), .reg_data(reg_data),
        .tok_in(tok_in), .token_out(token_out), .busy(busy),
        .ser_clk(ser_clk), .ser_data(ser_data)
    );

    // {region index, payload, trigger ID}
    localparam logic [28:0] VEC [6] = '{
        {5'd0,  20'hABCDE, 4'h1},
        {5'd7,  20'h12345, 4'hF},
        {5'd15, 20'hFFFFF, 4'h0},
        {5'd22, 20'h5A5A5, 4'h9},
        {5'd30, 20'hFFFFF, 4'h6},
        {5'd1,  20'h80001, 4'hA}
    };

    function automatic logic [31:0] exp_word(input int idx, input logic [19:0] pl,
                                             input logic [3:0] id);
        logic [31:0] w;
        w = '0;
        for (int p = 0; p < 4; p++) begin
            logic [4:0] px;
            px = pl[p*5 +: 5];
            if (idx == 30 && p >= 2) px = '0;
            w[31-p*5 -: 5] = px;
        end
        w[11:4] = 8'(idx);
        w[3:0]  = id;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_regions();
        reg_valid = '0;
        reg_id    = '0;
        reg_data  = '0;
    endtask

    task automatic set_region(input int idx, input logic [3:0] id, input logic [19:0] pl);
        reg_valid[idx] = 1'b1;
        reg_id[idx*ID_W +: ID_W] = id;
        reg_data[idx*RB +: RB] = pl;
    endtask

    task automatic pulse_trig(input logic [3:0] id);
        @(negedge clk);
        trig_req = 1'b1;
        trig_id  = id;
        @(negedge clk);
        trig_req = 1'b0;
    endtask

    // starts a read and captures one word on ser_clk high phases
    task automatic read_word(input bit hold_rd, output logic [31:0] w);
        w = '0;
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        if (!hold_rd) rd = 1'b0;
        chk(busy === 1'b1, "R3 busy at load", 32'(busy), 32'd1);
        for (int k = 0; k < 32; k++) begin
            if (k > 0) @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            w = {w[30:0], ser_data};
            if (ser_clk !== 1'b1) chk(1'b0, "R2 ser_clk high phase", 32'(ser_clk), 32'd1);
        end
        @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0, "R3 busy after 64 cycles", 32'(busy), 32'd0);
        rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy === 1'b0, "R11 busy", 32'(busy), 0);
        chk(token_out === 1'b0, "R11 token", 32'(token_out), 0);
        chk({ser_clk, ser_data} === 2'b00, "R11 serial", 32'({ser_clk, ser_data}), 0);
        rst_n = 1'b1;

        // table of single-region words (R1, R2, R5, R6, R8)
        for (int v = 0; v < 6; v++) begin
            int idx;
            idx = int'(VEC[v][28:24]);
            clr_regions();
            set_region(idx, VEC[v][3:0], VEC[v][23:4]);
            pulse_trig(VEC[v][3:0]);
            chk(token_out === 1'b1, "R6 token on match", 32'(token_out), 1);
            read_word(1'b0, w);
            chk(w === exp_word(idx, VEC[v][23:4], VEC[v][3:0]),
                (idx == 30) ? "R8 top tied word" : "R1 word layout",
                w, exp_word(idx, VEC[v][23:4], VEC[v][3:0]));
            chk(token_out === 1'b0, "R5 token drops", 32'(token_out), 0);
        end

        // R4 lowest index first, R5 token persists until all served
        clr_regions();
        set_region(9, 4'h2, 20'h11111);
        set_region(3, 4'h2, 20'h22222);
        pulse_trig(4'h2);
        read_word(1'b0, w);
        chk(w[11:4] === 8'd3, "R4 first addr", 32'(w[11:4]), 3);
        chk(token_out === 1'b1, "R5 token remains", 32'(token_out), 1);
        read_word(1'b0, w);
        chk(w === exp_word(9, 20'h11111, 4'h2), "R4 second word", w, exp_word(9, 20'h11111, 4'h2));
        chk(token_out === 1'b0, "R5 token cleared", 32'(token_out), 0);

        // R7 re-arm on trigger request
        pulse_trig(4'h2);
        chk(token_out === 1'b1, "R7 re-armed", 32'(token_out), 1);

        // R6 mismatch: no token, read loads nothing
        clr_regions();
        set_region(4, 4'h5, 20'h33333);
        pulse_trig(4'h6);
        chk(token_out === 1'b0, "R6 mismatch token", 32'(token_out), 0);
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        chk(busy === 1'b0, "R6 no load", 32'(busy), 0);

        // R12 read held while busy, then next word after idle
        clr_regions();
        set_region(4, 4'h6, 20'h0F0F0);
        set_region(5, 4'h6, 20'hF0F0F);
        pulse_trig(4'h6);
        read_word(1'b1, w);
        chk(w === exp_word(4, 20'h0F0F0, 4'h6), "R12 word intact", w, exp_word(4, 20'h0F0F0, 4'h6));
        read_word(1'b0, w);
        chk(w === exp_word(5, 20'hF0F0F, 4'h6), "R12 next word", w, exp_word(5, 20'hF0F0F, 4'h6));

        // R12 read coinciding with trigger request
        @(negedge clk); rd = 1'b1; trig_req = 1'b1; trig_id = 4'h6;
        @(negedge clk); rd = 1'b0; trig_req = 1'b0;
        chk(busy === 1'b0, "R12 trig blocks load", 32'(busy), 0);
        chk(token_out === 1'b1, "R7 token after trig", 32'(token_out), 1);

        // R9 column disabled
        cfg_dc_en = 1'b0;
        @(negedge clk);
        chk(token_out === 1'b0, "R9 token off", 32'(token_out), 0);
        rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        chk(busy === 1'b0, "R9 no load", 32'(busy), 0);

        // R10 neighbour token merge
        tok_in = 1'b1;
        @(negedge clk);
        chk(token_out === 1'b0, "R10 tok_in ignored", 32'(token_out), 0);
        cfg_chain_en = 1'b1;
        @(negedge clk);
        chk(token_out === 1'b1, "R10 tok_in merged", 32'(token_out), 1);
        cfg_chain_en = 1'b0; tok_in = 1'b0; cfg_dc_en = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule